// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is the register side of a 16-pin general-purpose I/O port. A simple register bus (write strobe, read strobe, 3-bit word address, 32-bit write and read data) reaches two configuration words, an output latch, a synchronized view of the pad inputs, two atomic output-update words and a configuration-lock word. Each pin's 4-bit configuration field is decoded into per-pin control lines for the pad logic: drive enable, open-drain, alternate-source select, analog, pull enable and pull direction.

Software uses the atomic words to change single output bits without a read-modify-write. A key sequence on the lock word freezes the configuration fields of a chosen set of pins until the next reset.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every configuration field reads 4'h4 (floating input), so both configuration words read 32'h4444_4444. The output latch reads 0, the lock word reads 0, and every decoded control line is 0.
- R2: Pin p owns bits [4p+3:4p] of the low configuration word (address 0) for p < 8, and bits [4(p-8)+3:4(p-8)] of the high word (address 1) otherwise. The low two bits of a field are the mode and the upper two are the configuration code. Mode 00 is input. Any other mode is output and raises drive enable. In output mode, configuration bit 0 selects open-drain and bit 1 selects the alternate source.
- R3: In input mode, configuration code 00 raises analog and code 10 raises pull enable. Codes 01 and 11 raise neither. When pull enable is high, pull direction equals the pin's output-latch bit (1 = up, 0 = down).
- R4: A write to address 3 loads bits [15:0] into the output latch. Reading address 3 returns the latch in bits [15:0] and zeros above.
- R5: A write to address 4 sets the latch bits where bits [15:0] are 1 and clears them where bits [31:16] are 1. Set wins when both are 1 for the same pin, and zero bits leave the latch unchanged.
- R6: A write to address 5 clears the latch bits where bits [15:0] are 1. Bits [31:16] are ignored.
- R7: Address 2 reads the pad inputs through two flip-flops, so a pad change first appears on a read two rising edges later. Writes to address 2 change nothing.
- R8: The lock word (address 6) has pin-select bits [15:0] and key bit 16. Writing key=1 with mask M, then key=0 with M, then key=1 with M, and then reading address 6 sets the key. From then on the word reads key=1 with the mask M.
- R9: While the key is set, the configuration fields of the selected pins never change. Writes still update the fields of unselected pins.
- R10: While the key is set, writes to the lock word change nothing until reset.
- R11: A wrong key value, a changed mask, or an extra lock-word write before the read aborts the sequence and leaves the key at 0. A key=1 write restarts detection. Until the key is set, every lock-word write stores its pin-select bits.
- R12: Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed to complete the lock sequence) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| pad_in | input | 16 | Asynchronous pad input levels |
| pin_dout | output | 16 | Output latch toward the pads |
| pin_out_en | output | 16 | Pin is in an output mode |
| pin_open_drain | output | 16 | Output driven open-drain |
| pin_alt_sel | output | 16 | Output taken from the alternate source |
| pin_analog | output | 16 | Pin in analog input mode |
| pin_pull_en | output | 16 | Input pull resistor enabled |
| pin_pull_up | output | 16 | Pull direction is up |

## Verification
The hardest state to reach is a completed lock, because it needs four bus operations in one exact order with a stable mask. The near misses each look like a valid prefix: a changed mask, a repeated key=1 write, and an extra write before the read. The stimulus plays each near miss and shows through the lock word and the configuration words that nothing froze. It then plays the exact sequence and shows that only the selected pins' fields hold against all-ones writes. A sweep of every field code across every pin position, with a varying output latch, covers the decode and the placement of the fields.

// File: rtl/gpio_port_regs.sv
module gpio_port_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [15:0] pad_in,
  output logic [15:0] pin_dout,
  output logic [15:0] pin_out_en,
  output logic [15:0] pin_open_drain,
  output logic [15:0] pin_alt_sel,
  output logic [15:0] pin_analog,
  output logic [15:0] pin_pull_en,
  output logic [15:0] pin_pull_up
);
  localparam int PINS = 16;
  localparam int FW   = 4;
  localparam int CW   = PINS * FW;
  localparam logic [2:0] A_CFG_LO = 3'd0, A_CFG_HI = 3'd1, A_IN  = 3'd2, A_OUT = 3'd3,
                         A_SETCLR = 3'd4, A_CLR    = 3'd5, A_LCK = 3'd6;
  localparam logic [31:0] CFG_RST = {(32/FW){4'h4}};

  logic [31:0] cfg_lo, cfg_hi;
  logic [15:0] odr, in_meta, in_sync, lck;
  logic        key;
  logic [1:0]  seq, seq_nx;
  logic [CW-1:0] cfg_all, lock_mask;

  wire wr_lo  = bus_wr && bus_addr == A_CFG_LO;
  wire wr_hi  = bus_wr && bus_addr == A_CFG_HI;
  wire wr_out = bus_wr && bus_addr == A_OUT;
  wire wr_sc  = bus_wr && bus_addr == A_SETCLR;
  wire wr_clr = bus_wr && bus_addr == A_CLR;
  wire wr_lck = bus_wr && bus_addr == A_LCK;
  wire rd_lck = bus_rd && !bus_wr && bus_addr == A_LCK;

  assign cfg_all  = {cfg_hi, cfg_lo};
  assign pin_dout = odr;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [1:0] md, cf;
    assign md = cfg_all[FW*p +: 2];
    assign cf = cfg_all[FW*p+2 +: 2];
    assign lock_mask[FW*p +: FW] = {FW{key & lck[p]}};
    assign pin_out_en[p]     = |md;
    assign pin_open_drain[p] = (|md) & cf[0];
    assign pin_alt_sel[p]    = (|md) & cf[1];
    assign pin_analog[p]     = ~(|md) & (cf == 2'b00);
    assign pin_pull_en[p]    = ~(|md) & (cf == 2'b10);
    assign pin_pull_up[p]    = pin_pull_en[p] & odr[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_lo <= CFG_RST;
      cfg_hi <= CFG_RST;
    end else begin
      if (wr_lo) cfg_lo <= (bus_wdata & ~lock_mask[31:0])  | (cfg_lo & lock_mask[31:0]);
      if (wr_hi) cfg_hi <= (bus_wdata & ~lock_mask[63:32]) | (cfg_hi & lock_mask[63:32]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      odr <= '0;
    else if (wr_out) odr <= bus_wdata[15:0];
    else if (wr_sc)  odr <= (odr & ~bus_wdata[31:16]) | bus_wdata[15:0];
    else if (wr_clr) odr <= odr & ~bus_wdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_meta <= '0;
      in_sync <= '0;
    end else begin
      in_meta <= pad_in;
      in_sync <= in_meta;
    end
  end

  always_comb begin
    case (seq)
      2'd1:    seq_nx = (!bus_wdata[16] && bus_wdata[15:0] == lck) ? 2'd2 : {1'b0, bus_wdata[16]};
      2'd2:    seq_nx = ( bus_wdata[16] && bus_wdata[15:0] == lck) ? 2'd3 : {1'b0, bus_wdata[16]};
      default: seq_nx = {1'b0, bus_wdata[16]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lck <= '0;
      key <= 1'b0;
      seq <= 2'd0;
    end else if (!key) begin
      if (wr_lck) begin
        lck <= bus_wdata[15:0];
        seq <= seq_nx;
      end else if (rd_lck && seq == 2'd3) begin
        key <= 1'b1;
        seq <= 2'd0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CFG_LO: bus_rdata = cfg_lo;
      A_CFG_HI: bus_rdata = cfg_hi;
      A_IN:     bus_rdata = {16'd0, in_sync};
      A_OUT:    bus_rdata = {16'd0, odr};
      A_LCK:    bus_rdata = {15'd0, key, lck};
      default:  bus_rdata = 32'd0;
    endcase
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sc |=> ((pin_dout & $past(bus_wdata[15:0])) == $past(bus_wdata[15:0])));

  assert_clear_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_dout & $past(bus_wdata[15:0])) == 16'd0));

  assert_key_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    key |=> (key && $stable(lck)));

  assert_key_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key) |-> $past(rd_lck));

  assert_locked_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key |=> ((((cfg_lo ^ $past(cfg_lo)) & lock_mask[31:0]) == 32'd0) &&
             (((cfg_hi ^ $past(cfg_hi)) & lock_mask[63:32]) == 32'd0)));
endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic [15:0] pad_in = 16'd0;
  logic [15:0] pin_dout, pin_out_en, pin_open_drain, pin_alt_sel, pin_analog, pin_pull_en, pin_pull_up;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port_regs i_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pin_dout(pin_dout),
    .pin_out_en(pin_out_en), .pin_open_drain(pin_open_drain), .pin_alt_sel(pin_alt_sel),
    .pin_analog(pin_analog), .pin_pull_en(pin_pull_en), .pin_pull_up(pin_pull_up));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // {out_en, open_drain, alt, analog, pull_en, pull_up}
  function automatic logic [5:0] dec(input logic [3:0] f, input logic o);
    logic oe;
    oe = f[1:0] != 2'b00;
    return {oe, oe & f[2], oe & f[3], !oe & f[3:2] == 2'b00,
            !oe & f[3:2] == 2'b10, !oe & f[3:2] == 2'b10 & o};
  endfunction

  task automatic lock_seq(input logic [15:0] m);
    wr(3'd6, {15'd0, 1'b1, m});
    wr(3'd6, {15'd0, 1'b0, m});
    wr(3'd6, {15'd0, 1'b1, m});
  endtask

  task automatic check_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1 cfg_lo", d, 32'h4444_4444);
    rd(3'd1, d); chk("R1 cfg_hi", d, 32'h4444_4444);
    rd(3'd3, d); chk("R1 out", d, 32'd0);
    rd(3'd6, d); chk("R1 lock", d, 32'd0);
    chk("R1 decode", {pin_out_en, pin_open_drain}, 32'd0);
    chk("R1 decode", {pin_alt_sel, pin_analog}, 32'd0);
    chk("R1 decode", {pin_pull_en, pin_pull_up}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, lo, hi, exp32;
    logic [15:0] exp, m;
    logic [63:0] all;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset();

    // R2 R3: every code at every pin position
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 8; p++) begin
        lo[4*p +: 4] = 4'((c + p) % 16);
        hi[4*p +: 4] = 4'((c + p + 8) % 16);
      end
      exp = 16'hA5C3 ^ 16'(c * 16'h1111);
      wr(3'd0, lo); wr(3'd1, hi); wr(3'd3, {16'hFFFF, exp});
      rd(3'd0, d); chk("R2 lo readback", d, lo);
      rd(3'd1, d); chk("R2 hi readback", d, hi);
      all = {hi, lo};
      for (int p = 0; p < 16; p++)
        chk("R2 R3 pin decode",
            {26'd0, pin_out_en[p], pin_open_drain[p], pin_alt_sel[p], pin_analog[p], pin_pull_en[p], pin_pull_up[p]},
            {26'd0, dec(all[4*p +: 4], exp[p])});
    end

    // R4
    for (int i = 0; i < 8; i++) begin
      exp = 16'(i * 16'h3B71 + 16'h0F0F);
      wr(3'd3, {16'(i * 16'h5555), exp});
      rd(3'd3, d); chk("R4 out readback", d, {16'd0, exp});
      chk("R4 pin_dout", {16'd0, pin_dout}, {16'd0, exp});
    end

    // R5
    exp = pin_dout;
    for (int i = 0; i < 64; i++) begin
      logic [15:0] s, k;
      s = 16'(i * 16'h2F1B) ^ 16'h003C;
      k = 16'(i * 16'h91D3);
      exp = (exp & ~k) | s;
      wr(3'd4, {k, s});
      chk("R5 set/clear", {16'd0, pin_dout}, {16'd0, exp});
    end
    wr(3'd3, 32'h0000_0F0F);
    wr(3'd4, {16'hFFFF, 16'h00FF});
    chk("R5 set wins", {16'd0, pin_dout}, 32'h0000_00FF);
    wr(3'd4, 32'd0);
    chk("R5 zero unchanged", {16'd0, pin_dout}, 32'h0000_00FF);

    // R6
    wr(3'd3, 32'h0000_FFFF);
    exp = 16'hFFFF;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] c16;
      c16 = 16'(1 << i) | 16'(i * 16'h0101);
      exp = exp & ~c16;
      wr(3'd5, {16'hFFFF, c16});
      chk("R6 clear only", {16'd0, pin_dout}, {16'd0, exp});
      wr(3'd3, {16'd0, exp | 16'h8000});
      exp = exp | 16'h8000;
    end

    // R7
    for (int i = 0; i < 6; i++) begin
      logic [15:0] old;
      old = pad_in;
      @(negedge clk); pad_in = 16'(i * 16'h4D2B + 16'h1001); bus_addr = 3'd2;
      @(negedge clk); chk("R7 one edge", bus_rdata, {16'd0, old});
      @(negedge clk); chk("R7 two edges", bus_rdata, {16'd0, pad_in});
    end
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); chk("R7 write ignored", d, {16'd0, pad_in});
    rd(3'd3, d); chk("R7 write ignored out", d, {16'd0, exp});

    // R12
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, d); chk("R12 unused", d, 32'd0);

    // R11 aborted sequences
    wr(3'd6, 32'h0001_1234); wr(3'd6, 32'h0000_4321); wr(3'd6, 32'h0001_4321);
    rd(3'd6, d); rd(3'd6, d); chk("R11 mask change", d, 32'h0000_4321);
    wr(3'd6, 32'h0001_00FF); wr(3'd6, 32'h0001_00FF); wr(3'd6, 32'h0001_00FF);
    rd(3'd6, d); rd(3'd6, d); chk("R11 wrong key", d, 32'h0000_00FF);
    lock_seq(16'hF00F); wr(3'd6, 32'h0001_F00F);
    rd(3'd6, d); rd(3'd6, d); chk("R11 extra write", d, 32'h0000_F00F);
    wr(3'd6, 32'h0000_ABCD);
    rd(3'd6, d); chk("R11 bits writable", d, 32'h0000_ABCD);
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R11 nothing frozen lo", d, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R11 nothing frozen hi", d, 32'hFFFF_FFFF);

    // R8 R9 R10
    m = 16'h81A5;
    wr(3'd0, 32'd0); wr(3'd1, 32'd0);
    lock_seq(m);
    rd(3'd6, d); chk("R8 key before read", d, {15'd0, 1'b0, m});
    rd(3'd6, d); chk("R8 key set", d, {15'd0, 1'b1, m});
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    for (int p = 0; p < 16; p++) all[4*p +: 4] = m[p] ? 4'h0 : 4'hF;
    rd(3'd0, d); chk("R9 locked lo", d, all[31:0]);
    rd(3'd1, d); chk("R9 locked hi", d, all[63:32]);
    wr(3'd0, 32'h1234_5678);
    exp32 = 32'h1234_5678;
    for (int p = 0; p < 8; p++) if (m[p]) exp32[4*p +: 4] = 4'h0;
    rd(3'd0, d); chk("R9 partial write", d, exp32);
    wr(3'd6, 32'h0000_0000); lock_seq(16'h0001);
    rd(3'd6, d); chk("R10 lock word frozen", d, {15'd0, 1'b1, m});

    // R1 again after a second reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_reset();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule